// File: doc/BRIEF.md
# Integer Compare and Conditional Move Unit

This unit evaluates one 64-bit integer operation per cycle: either a relational compare between operand A and operand B that yields a full-width 0 or 1, or a conditional move that tests operand A alone and, when the test holds, hands operand B to the destination. Operand B comes either from a register value or from an 8-bit literal that is zero-extended to 64 bits. A separate write-enable tells the register file whether to update the destination. A failed conditional move leaves the destination unchanged.

The result, the write-enable and a valid flag are registered, so every operation presented with `valid_i` high appears at the outputs one clock later. The register file and any forwarding logic sit outside the block.

Top module: `cmpmov_unit`

## Requirements
- R1: While `rst_n` is low, `valid_o`, `we_o` and `res_o` are all zero.
- R2: Each result appears one clock edge after its inputs are sampled. When `valid_i` is low at an edge, the next `valid_o`, `we_o` and `res_o` are all zero.
- R3: Opcode 0 (equal) produces 1 when A equals the effective B, and 0 otherwise.
- R4: Opcode 1 (signed less-than) and opcode 2 (signed less-or-equal) compare A and B as two's-complement numbers.
- R5: Opcode 3 (unsigned less-than) and opcode 4 (unsigned less-or-equal) compare A and B as unsigned numbers.
- R6: Every compare (opcodes 0 to 4) drives `we_o` high and leaves bits 63..1 of `res_o` at zero.
- R7: Opcodes 8 to 13 are conditional moves that test A as a signed value: 8 A==0, 9 A!=0, 10 A<0, 11 A>=0, 12 A<=0, 13 A>0.
- R8: Opcode 14 moves when bit 0 of A is 1, and opcode 15 moves when bit 0 of A is 0.
- R9: For a conditional move, `res_o` is always the effective B, and `we_o` is high only when the condition holds.
- R10: When `use_lit_i` is high, the effective B is `lit_i` zero-extended to 64 bits, so it is never negative. When `use_lit_i` is low, the effective B is `b_i`.
- R11: Opcodes 5, 6 and 7 are reserved. They give `valid_o` high, `we_o` low and `res_o` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code (see R3 to R11) |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Register form of operand B |
| lit_i | input | 8 | Literal form of operand B |
| use_lit_i | input | 1 | Select the literal as operand B |
| valid_o | output | 1 | Result valid |
| we_o | output | 1 | Destination write-enable |
| res_o | output | 64 | Destination value |

## Verification
Every result is due exactly one rising edge after its inputs are driven. The driver applies inputs on the falling edge and pushes the expected valid, write-enable and data into a queue. The monitor wakes shortly after the next rising edge and pops exactly the item for that edge, so no check samples early or late. Idle cycles also push an all-zero expectation, which checks the valid-low behaviour in the cycle it applies to.

// File: rtl/cmpmov_pkg.sv
package cmpmov_pkg;
    localparam int DATA_W = 64;
    localparam int LIT_W  = 8;
    localparam int OP_W   = 4;

    // compare opcodes (op[3] == 0)
    localparam logic [OP_W-1:0] OP_EQ  = 4'd0;
    localparam logic [OP_W-1:0] OP_LTS = 4'd1;
    localparam logic [OP_W-1:0] OP_LES = 4'd2;
    localparam logic [OP_W-1:0] OP_LTU = 4'd3;
    localparam logic [OP_W-1:0] OP_LEU = 4'd4;

    // conditional-move tests, selected by op[2:0] when op[3] == 1
    localparam logic [2:0] MV_EQZ = 3'd0;
    localparam logic [2:0] MV_NEZ = 3'd1;
    localparam logic [2:0] MV_LTZ = 3'd2;
    localparam logic [2:0] MV_GEZ = 3'd3;
    localparam logic [2:0] MV_LEZ = 3'd4;
    localparam logic [2:0] MV_GTZ = 3'd5;
    localparam logic [2:0] MV_LBS = 3'd6;
    localparam logic [2:0] MV_LBC = 3'd7;
endpackage

// File: rtl/cmpmov_opnd_sel.sv
module cmpmov_opnd_sel #(
    parameter int DW = cmpmov_pkg::DATA_W,
    parameter int LW = cmpmov_pkg::LIT_W
) (
    input  logic [DW-1:0] reg_val,
    input  logic [LW-1:0] lit_val,
    input  logic          use_lit,
    output logic [DW-1:0] opnd
);
    localparam int PAD_W = DW - LW;

    logic [DW-1:0] lit_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign lit_ext = {{PAD_W{1'b0}}, lit_val};
        end else begin : g_nopad
            assign lit_ext = lit_val[DW-1:0];
        end
    endgenerate

    always_comb begin
        opnd = use_lit ? lit_ext : reg_val;
    end
endmodule

// File: rtl/cmpmov_cmp_core.sv
module cmpmov_cmp_core #(
    parameter int DW = cmpmov_pkg::DATA_W
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [2:0]    sel,
    output logic          hit
);
    import cmpmov_pkg::*;

    logic [DW:0] diff;
    logic        eq;
    logic        lt_u;
    logic        lt_s;

    always_comb begin
        // one shared subtractor: borrow gives unsigned less-than
        diff = {1'b0, a} - {1'b0, b};
        eq   = (a == b);
        lt_u = diff[DW];
        lt_s = (a[DW-1] != b[DW-1]) ? a[DW-1] : lt_u;
        unique case ({1'b0, sel})
            OP_EQ:   hit = eq;
            OP_LTS:  hit = lt_s;
            OP_LES:  hit = lt_s | eq;
            OP_LTU:  hit = lt_u;
            OP_LEU:  hit = lt_u | eq;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmpmov_cond_eval.sv
module cmpmov_cond_eval #(
    parameter int DW = cmpmov_pkg::DATA_W
) (
    input  logic [DW-1:0] a,
    input  logic [2:0]    cond,
    output logic          hit
);
    import cmpmov_pkg::*;

    logic zero;
    logic neg;

    always_comb begin
        zero = (a == '0);
        neg  = a[DW-1];
        unique case (cond)
            MV_EQZ:  hit = zero;
            MV_NEZ:  hit = ~zero;
            MV_LTZ:  hit = neg;
            MV_GEZ:  hit = ~neg;
            MV_LEZ:  hit = neg | zero;
            MV_GTZ:  hit = ~neg & ~zero;
            MV_LBS:  hit = a[0];
            default: hit = ~a[0];
        endcase
    end
endmodule

// File: rtl/cmpmov_unit.sv
module cmpmov_unit #(
    parameter int DATA_W = cmpmov_pkg::DATA_W,
    parameter int LIT_W  = cmpmov_pkg::LIT_W,
    parameter int OP_W   = cmpmov_pkg::OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [LIT_W-1:0]  lit_i,
    input  logic              use_lit_i,
    output logic              valid_o,
    output logic              we_o,
    output logic [DATA_W-1:0] res_o
);
    import cmpmov_pkg::*;

    typedef struct packed {
        logic              valid;
        logic              we;
        logic [DATA_W-1:0] res;
    } stage_t;

    stage_t            out_d;
    stage_t            out_q;
    logic [DATA_W-1:0] b_eff;
    logic              cmp_hit;
    logic              mv_hit;

    cmpmov_opnd_sel #(.DW(DATA_W), .LW(LIT_W)) u_sel (
        .reg_val (b_i),
        .lit_val (lit_i),
        .use_lit (use_lit_i),
        .opnd    (b_eff)
    );

    cmpmov_cmp_core #(.DW(DATA_W)) u_cmp (
        .a   (a_i),
        .b   (b_eff),
        .sel (op_i[2:0]),
        .hit (cmp_hit)
    );

    cmpmov_cond_eval #(.DW(DATA_W)) u_cond (
        .a    (a_i),
        .cond (op_i[2:0]),
        .hit  (mv_hit)
    );

    always_comb begin
        out_d = '0;
        if (valid_i) begin
            out_d.valid = 1'b1;
            if (op_i[OP_W-1]) begin
                out_d.we  = mv_hit;
                out_d.res = b_eff;
            end else if (op_i <= OP_LEU) begin
                out_d.we  = 1'b1;
                out_d.res = {{(DATA_W-1){1'b0}}, cmp_hit};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign valid_o = out_q.valid;
    assign we_o    = out_q.we;
    assign res_o   = out_q.res;

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!valid_o && !we_o && res_o == '0));
    p_cmp_bool_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !op_i[OP_W-1] && op_i <= OP_LEU) |=> (we_o && res_o[DATA_W-1:1] == '0));
    p_mv_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i[OP_W-1]) |=>
            res_o == $past(use_lit_i ? {{(DATA_W-LIT_W){1'b0}}, lit_i} : b_i));
    p_mv_eqz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == {1'b1, MV_EQZ}) |=> (we_o == ($past(a_i) == '0)));
    p_mv_lbs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == {1'b1, MV_LBS}) |=> (we_o == $past(a_i[0])));
    p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !op_i[OP_W-1] && op_i > OP_LEU) |=> (valid_o && !we_o && res_o == '0));
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |-> (!valid_o && !we_o && res_o == '0));
endmodule

// File: tb/sim_cmpmov_unit.sv
module sim_cmpmov_unit;
    logic        clk;
    logic        rst_n;
    logic        valid_i;
    logic [3:0]  op_i;
    logic [63:0] a_i;
    logic [63:0] b_i;
    logic [7:0]  lit_i;
    logic        use_lit_i;
    logic        valid_o;
    logic        we_o;
    logic [63:0] res_o;

    int checks = 0;
    int errors = 0;

    logic [65:0] q_exp[$];
    string       q_tag[$];
    logic [63:0] bnd[6];

    cmpmov_unit u0 (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .lit_i(lit_i), .use_lit_i(use_lit_i),
        .valid_o(valid_o), .we_o(we_o), .res_o(res_o)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // expected {valid, we, res} derived from the requirements
    function automatic logic [65:0] model(input logic [3:0] op, input logic [63:0] a,
                                          input logic [63:0] b);
        logic hit;
        hit = 1'b0;
        if (op >= 4'd8) begin
            case (op)
                4'd8:    hit = (a == 64'd0);
                4'd9:    hit = (a != 64'd0);
                4'd10:   hit = ($signed(a) < 0);
                4'd11:   hit = ($signed(a) >= 0);
                4'd12:   hit = ($signed(a) <= 0);
                4'd13:   hit = ($signed(a) > 0);
                4'd14:   hit = (a[0] == 1'b1);
                default: hit = (a[0] == 1'b0);
            endcase
            return {1'b1, hit, b};
        end
        case (op)
            4'd0: return {2'b11, 63'd0, a == b};
            4'd1: return {2'b11, 63'd0, $signed(a) < $signed(b)};
            4'd2: return {2'b11, 63'd0, $signed(a) <= $signed(b)};
            4'd3: return {2'b11, 63'd0, a < b};
            4'd4: return {2'b11, 63'd0, a <= b};
            default: return {2'b10, 64'd0};
        endcase
    endfunction

    task automatic drive(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                         input logic [7:0] lit, input logic use_lit, input string tag);
        @(negedge clk);
        valid_i = 1'b1; op_i = op; a_i = a; b_i = b; lit_i = lit; use_lit_i = use_lit;
        q_exp.push_back(model(op, a, use_lit ? {56'd0, lit} : b));
        q_tag.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        valid_i = 1'b0; op_i = 4'd0; a_i = 64'hDEAD_BEEF_0000_0001; b_i = '1; lit_i = 8'hFF; use_lit_i = 1'b0;
        q_exp.push_back(66'd0);
        q_tag.push_back("R2 idle");
    endtask

    // monitor: each item is due one rising edge after the driver pushed it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && q_exp.size() > 0) begin
                logic [65:0] e;
                logic [65:0] got;
                string       t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                got = {valid_o, we_o, res_o};
                checks++;
                if (got != e) begin
                    errors++;
                    $display("FAIL %s: got v=%0b we=%0b res=%h expected v=%0b we=%0b res=%h",
                             t, got[65], got[64], got[63:0], e[65], e[64], e[63:0]);
                end
            end
        end
    end

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bnd[0] = 64'h8000_0000_0000_0000;
        bnd[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        bnd[2] = 64'd0;
        bnd[3] = 64'd1;
        bnd[4] = 64'h7FFF_FFFF_FFFF_FFFF;
        bnd[5] = 64'd2;
        rst_n = 1'b0; valid_i = 1'b1; op_i = 4'd8; a_i = '0; b_i = 64'h55;
        lit_i = 8'd0; use_lit_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if ({valid_o, we_o, res_o} != 66'd0) begin
            errors++;
            $display("FAIL R1 reset: got v=%0b we=%0b res=%h expected 0 0 0", valid_o, we_o, res_o);
        end
        valid_i = 1'b0;
        rst_n = 1'b1;

        // compares over all boundary pairs: R3 R4 R5 with R6
        for (int op = 0; op < 5; op++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    drive(op[3:0], bnd[i], bnd[j], 8'h00, 1'b0,
                          op == 0 ? "R3 R6 eq" : (op < 3 ? "R4 R6 signed" : "R5 R6 unsigned"));
                end
            end
        end
        idle();
        // conditional moves: R7 sign tests, R8 low-bit tests, R9 data
        for (int c = 8; c < 16; c++) begin
            for (int i = 0; i < 6; i++) begin
                drive(c[3:0], bnd[i], 64'hA5A5_0000_1234_5678 + 64'(i), 8'h00, 1'b0,
                      c < 14 ? "R7 R9 sign cmov" : "R8 R9 lowbit cmov");
            end
        end
        idle();
        // literal operand, zero-extended: R10
        drive(4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 8'hFF, 1'b1, "R10 lit signed lt");
        drive(4'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 8'hFF, 1'b1, "R10 lit unsigned lt");
        drive(4'd0, 64'd255, 64'hFF, 8'hFF, 1'b1, "R10 lit eq");
        drive(4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b1, "R10 lit no sign ext");
        drive(4'd4, 64'd128, 64'd0, 8'h80, 1'b1, "R10 lit leu");
        drive(4'd9, 64'd7, 64'hFFFF, 8'h9C, 1'b1, "R10 R9 lit cmov");
        drive(4'd8, 64'd7, 64'hFFFF, 8'h9C, 1'b1, "R10 R9 lit cmov false");
        // reserved opcodes: R11
        for (int r = 5; r < 8; r++) begin
            drive(r[3:0], 64'd3, 64'd3, 8'h00, 1'b0, "R11 reserved");
        end
        // back-to-back with idle gaps: R2
        drive(4'd2, 64'd5, 64'd5, 8'h00, 1'b0, "R2 R4 back-to-back");
        idle();
        drive(4'd13, 64'd5, 64'd9, 8'h00, 1'b0, "R2 R7 after idle");
        idle();
        idle();
        repeat (3) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule